// File: doc/BRIEF.md
# Byte-Lane Static RAM Model with Clock-Sampled Strobes

This block is a synthesizable model of a word-organised static RAM with active-low control strobes. The strobes are a select, a write strobe, an output strobe and one enable per byte lane. In the full configuration the array is 65,536 words of 16 bits with a 16-bit address. The depth is a parameter, `ADDR_W`. The default elaboration uses `ADDR_W = 10` to keep the array small, and setting it to 16 gives the full size.

The data pins are split into a write-data input and a read-data output. A per-lane drive flag stands in for the tri-state pins. A lane that is not driven presents zero on its slice of the read-data output. Every control is sampled on the rising clock edge, so the strobe overlaps that an asynchronous part would see become sequences of samples.

A four-state controller decides what each sample means:

- **STANDBY**: select high.
- **SELECTED**: selected, but no transfer.
- **READING**: a read.
- **WRITING**: the write window is open.

Each state moves according to the strobes sampled at the edge:

- **deselect**: any state goes to STANDBY when select is sampled high.
- **open-write**: the select and write strobes are low and at least one lane enable is low, so the controller goes to, or stays in, WRITING.
- **start-read**: select and output strobe are low, the write strobe is high and at least one lane enable is low, so the controller goes to READING.
- **idle-select**: any other selected combination leads to SELECTED.

Leaving WRITING by any of these transitions is the **close-write** event, which commits the held write.

Top module: `sram_byte_lane_model`

## Requirements
- R1: The array holds 2**ADDR_W words of LANES x LANE_W bits. A full-word write followed by a full-word read of the same address returns the written word.
- R2: The write window is open at every sample with `sel_n`=0, `wen_n`=0 and at least one `lane_n` bit low. The write is committed at the first sample where the window is closed. It stores `wdata` as present at that closing sample, at the address and lanes from the last sample inside the window.
- R3: Lane 0 is bits 7:0 and is enabled by `lane_n[0]`=0. Lane 1 is bits 15:8 and is enabled by `lane_n[1]`=0. A write leaves any lane whose enable was high unchanged.
- R4: A sample with `sel_n`=0, `wen_n`=1 and `oen_n`=0 is a read. After that edge, `drive_en[i]` is 1 exactly for the lanes with `lane_n[i]`=0, and those lanes of `rdata` carry the stored data.
- R5: `drive_en` is 0 for both lanes after any sample with `sel_n`=1, `oen_n`=1, both `lane_n` bits high, or `wen_n`=0. An undriven lane shows 0 on `rdata`.
- R6: `standby` is 1 after an edge that sampled `sel_n`=1, and 0 after an edge that sampled `sel_n`=0. All other inputs are ignored in that state.
- R7: When `sel_n` and `wen_n` rise at the same sample, the write commits and both lanes stay undriven, with no read data shown.
- R8: A read sampled at the same edge as a commit to the same address returns the newly written lanes.
- R9: A synchronous active-low reset puts the controller in STANDBY, with `standby`=1, `drive_en`=0 and `rdata`=0. The array contents are kept across reset.
- R10: `wen_n`=0 with both lane enables high opens no write window and changes no stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low select |
| wen_n | input | 1 | Active-low write strobe |
| oen_n | input | 1 | Active-low output strobe |
| lane_n | input | LANES (2) | Active-low byte-lane enables, bit 0 = low byte |
| addr | input | ADDR_W (10) | Word address |
| wdata | input | LANES*LANE_W (16) | Write data |
| rdata | output | LANES*LANE_W (16) | Read data, zero on undriven lanes |
| drive_en | output | LANES (2) | Per-lane drive flag, models the tri-state enable |
| standby | output | 1 | High while deselected |

## Verification
The hardest situations to reach are the ones where the end of a write window coincides with something else. One is the data changing while the window is still open. Another is select and the write strobe rising on the same sample. A third is a read of the same address starting on exactly the commit sample. The vector table drives each of these in turn:

- a three-sample write whose data changes at every sample, so only the closing sample's value may survive;
- a write closed by a deselect, followed by a read-back;
- a write whose closing sample is also a read of the same address, so a stale read shows up immediately.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;
    typedef enum logic [1:0] {
        ST_STANDBY  = 2'd0,
        ST_SELECTED = 2'd1,
        ST_READING  = 2'd2,
        ST_WRITING  = 2'd3
    } sram_state_e;
endpackage

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
    import sram_lane_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             wen_n,
    input  logic             oen_n,
    input  logic [LANES-1:0] lane_n,
    output logic             capture,
    output logic             commit,
    output logic [LANES-1:0] rd_lane,
    output logic             standby
);
    sram_state_e state_q;
    sram_state_e state_d;
    logic        any_lane;

    assign any_lane = ~&lane_n;

    // next-state decision from the sampled strobes
    always_comb begin
        if (sel_n) begin
            state_d = ST_STANDBY;                 // deselect
        end else if (!wen_n && any_lane) begin
            state_d = ST_WRITING;                 // open-write
        end else if (wen_n && !oen_n && any_lane) begin
            state_d = ST_READING;                 // start-read
        end else begin
            state_d = ST_SELECTED;                // idle-select
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        commit  = 1'b0;
        standby = 1'b0;
        capture = (state_d == ST_WRITING);
        rd_lane = (state_d == ST_READING) ? ~lane_n : '0;
        unique case (state_q)
            ST_STANDBY:  standby = 1'b1;
            ST_SELECTED: standby = 1'b0;
            ST_READING:  standby = 1'b0;
            ST_WRITING:  commit  = rst_n && (state_d != ST_WRITING); // close-write
        endcase
    end

    // R6
    standby_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> standby);

    // R6
    standby_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |=> !standby);
endmodule

// File: rtl/sram_lane.sv
`timescale 1ns/1ps
module sram_lane #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [LANE_W-1:0] rd_data,
    output logic              drive
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];
    logic              fwd;

    // storage is never reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign fwd = wr_en && (wr_addr == rd_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            drive   <= 1'b0;
        end else begin
            drive   <= rd_en;
            rd_data <= rd_en ? (fwd ? wr_data : mem[rd_addr]) : '0;
        end
    end

    // R8
    forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fwd && rd_en)) |-> (rd_data == $past(wr_data)));
endmodule

// File: rtl/sram_byte_lane_model.sv
`timescale 1ns/1ps
module sram_byte_lane_model
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wen_n,
    input  logic              oen_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  drive_en,
    output logic              standby
);
    logic              capture;
    logic              commit;
    logic [LANES-1:0]  rd_lane;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [LANES-1:0]  wr_mask_q;

    sram_ctrl_fsm #(.LANES(LANES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .wen_n   (wen_n),
        .oen_n   (oen_n),
        .lane_n  (lane_n),
        .capture (capture),
        .commit  (commit),
        .rd_lane (rd_lane),
        .standby (standby)
    );

    // address and lane mask of the last in-window sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr_q <= '0;
            wr_mask_q <= '0;
        end else if (capture) begin
            wr_addr_q <= addr;
            wr_mask_q <= ~lane_n;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (commit && wr_mask_q[g]),
            .wr_addr (wr_addr_q),
            .wr_data (wdata[g*LANE_W +: LANE_W]),
            .rd_en   (rd_lane[g]),
            .rd_addr (addr),
            .rd_data (rdata[g*LANE_W +: LANE_W]),
            .drive   (drive_en[g])
        );

        // R4
        lane_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            drive_en[g] |-> $past(!sel_n && wen_n && !oen_n && !lane_n[g]));
    end

    // R5
    write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wen_n) |=> (drive_en == '0));

    // R7
    deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (drive_en == '0));
endmodule

// File: tb/sram_byte_lane_model_bench.sv
`timescale 1ns/1ps
module sram_byte_lane_model_bench;
    typedef struct packed {
        logic        sel_n;
        logic        wen_n;
        logic        oen_n;
        logic [1:0]  lane_n;
        logic [9:0]  addr;
        logic [15:0] wdata;
        logic [1:0]  exp_en;
        logic [15:0] exp_data;
        logic        exp_sb;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 1'b1, 2'b11, 10'd0,  16'h0000, 2'b00, 16'h0000, 1'b1, 4'd6 },  // R6 idle standby
        '{1'b0, 1'b0, 1'b1, 2'b00, 10'd5,  16'h1234, 2'b00, 16'h0000, 1'b0, 4'd5 },  // R5 window open, undriven
        '{1'b0, 1'b1, 1'b1, 2'b11, 10'd5,  16'h1234, 2'b00, 16'h0000, 1'b0, 4'd2 },  // R2 close -> commit
        '{1'b0, 1'b1, 1'b0, 2'b00, 10'd5,  16'h0000, 2'b11, 16'h1234, 1'b0, 4'd1 },  // R1 full read
        '{1'b0, 1'b0, 1'b1, 2'b10, 10'd5,  16'hABCD, 2'b00, 16'h0000, 1'b0, 4'd3 },  // R3 low lane only
        '{1'b0, 1'b1, 1'b1, 2'b11, 10'd5,  16'hABCD, 2'b00, 16'h0000, 1'b0, 4'd3 },
        '{1'b0, 1'b1, 1'b0, 2'b00, 10'd5,  16'h0000, 2'b11, 16'h12CD, 1'b0, 4'd3 },  // R3 high kept
        '{1'b0, 1'b0, 1'b1, 2'b01, 10'd5,  16'h9977, 2'b00, 16'h0000, 1'b0, 4'd3 },  // R3 high lane only
        '{1'b0, 1'b1, 1'b1, 2'b11, 10'd5,  16'h9977, 2'b00, 16'h0000, 1'b0, 4'd3 },
        '{1'b0, 1'b1, 1'b0, 2'b01, 10'd5,  16'h0000, 2'b10, 16'h9900, 1'b0, 4'd4 },  // R4 upper read
        '{1'b0, 1'b1, 1'b0, 2'b10, 10'd5,  16'h0000, 2'b01, 16'h00CD, 1'b0, 4'd4 },  // R4 lower read
        '{1'b0, 1'b0, 1'b1, 2'b00, 10'd7,  16'h1111, 2'b00, 16'h0000, 1'b0, 4'd2 },  // R2 long window
        '{1'b0, 1'b0, 1'b1, 2'b00, 10'd7,  16'h2222, 2'b00, 16'h0000, 1'b0, 4'd2 },
        '{1'b0, 1'b1, 1'b1, 2'b11, 10'd7,  16'h3333, 2'b00, 16'h0000, 1'b0, 4'd2 },
        '{1'b0, 1'b1, 1'b0, 2'b00, 10'd7,  16'h0000, 2'b11, 16'h3333, 1'b0, 4'd2 },  // R2 closing data
        '{1'b0, 1'b0, 1'b1, 2'b11, 10'd5,  16'hFFFF, 2'b00, 16'h0000, 1'b0, 4'd10},  // R10 no lane
        '{1'b0, 1'b1, 1'b1, 2'b11, 10'd5,  16'hFFFF, 2'b00, 16'h0000, 1'b0, 4'd10},
        '{1'b0, 1'b1, 1'b0, 2'b00, 10'd5,  16'h0000, 2'b11, 16'h99CD, 1'b0, 4'd10},  // R10 unchanged
        '{1'b0, 1'b1, 1'b1, 2'b00, 10'd5,  16'h0000, 2'b00, 16'h0000, 1'b0, 4'd5 },  // R5 oen high
        '{1'b1, 1'b1, 1'b0, 2'b00, 10'd5,  16'h0000, 2'b00, 16'h0000, 1'b1, 4'd6 },  // R6 deselected read
        '{1'b0, 1'b0, 1'b1, 2'b00, 10'd9,  16'h4242, 2'b00, 16'h0000, 1'b0, 4'd7 },  // R7 window
        '{1'b1, 1'b1, 1'b0, 2'b00, 10'd9,  16'h4242, 2'b00, 16'h0000, 1'b1, 4'd7 },  // R7 joint rise
        '{1'b0, 1'b1, 1'b0, 2'b00, 10'd9,  16'h0000, 2'b11, 16'h4242, 1'b0, 4'd7 },  // R7 committed
        '{1'b0, 1'b0, 1'b0, 2'b00, 10'd10, 16'h5A5A, 2'b00, 16'h0000, 1'b0, 4'd5 },  // R5 oen low in write
        '{1'b0, 1'b1, 1'b0, 2'b00, 10'd10, 16'h5A5A, 2'b11, 16'h5A5A, 1'b0, 4'd8 }   // R8 read on commit
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        wen_n = 1'b1;
    logic        oen_n = 1'b1;
    logic [1:0]  lane_n = 2'b11;
    logic [9:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  drive_en;
    logic        standby;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sram_byte_lane_model u_sram_byte_lane_model (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .wen_n    (wen_n),
        .oen_n    (oen_n),
        .lane_n   (lane_n),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .drive_en (drive_en),
        .standby  (standby)
    );

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp_v);
        end
    endtask

    task automatic apply(input logic s, input logic w, input logic o,
                         input logic [1:0] ln, input logic [9:0] a,
                         input logic [15:0] d);
        @(negedge clk);
        sel_n = s; wen_n = w; oen_n = o; lane_n = ln; addr = a; wdata = d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        // R9 reset state
        repeat (3) @(posedge clk);
        #2;
        check(9, "reset standby", {15'd0, standby}, 16'h0001);
        check(9, "reset drive_en", {14'd0, drive_en}, 16'h0000);
        check(9, "reset rdata", rdata, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].sel_n, TBL[i].wen_n, TBL[i].oen_n,
                  TBL[i].lane_n, TBL[i].addr, TBL[i].wdata);
            check(int'(TBL[i].req), $sformatf("row %0d drive_en", i),
                  {14'd0, drive_en}, {14'd0, TBL[i].exp_en});
            check(int'(TBL[i].req), $sformatf("row %0d rdata", i),
                  rdata, TBL[i].exp_data);
            check(int'(TBL[i].req), $sformatf("row %0d standby", i),
                  {15'd0, standby}, {15'd0, TBL[i].exp_sb});
        end

        // R9 reset mid-run with a read requested: outputs cleared
        @(negedge clk);
        rst_n = 1'b0;
        sel_n = 1'b0; wen_n = 1'b1; oen_n = 1'b0; lane_n = 2'b00; addr = 10'd5;
        @(posedge clk);
        #2;
        check(9, "mid reset drive_en", {14'd0, drive_en}, 16'h0000);
        check(9, "mid reset rdata", rdata, 16'h0000);
        check(9, "mid reset standby", {15'd0, standby}, 16'h0001);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        // R9 contents survive reset
        check(9, "kept word drive_en", {14'd0, drive_en}, 16'h0003);
        check(9, "kept word rdata", rdata, 16'h99CD);
        apply(1'b0, 1'b1, 1'b0, 2'b10, 10'd7, 16'h0000);
        check(9, "kept low lane rdata", rdata, 16'h0033);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule